// File: doc/BRIEF.md
# Dot-Dash Store Display Renderer

This block turns the contents of a 32-word by 32-bit store into a live 640x480 picture with no frame buffer. Every word of the store is drawn as one horizontal band of marks: a short green mark for a zero bit and a long green mark for a one bit, each in its own 16-pixel cell. Each band is four scan lines tall and is followed by eight dark lines, so 32 words fill 384 lines. A parameterised offset places the whole picture on the screen, both horizontally and vertically.

The block sits beside an existing VGA timing generator and takes its pixel counter, line counter and active-video flag. The store itself is held inside the block as a dual-port RAM. One port takes writes from the processor side. The renderer reads the other port once per scan line, during horizontal blanking, to fetch the word for the next line. Each pixel's bit is then picked from that word by a multiplexer that is steered by the pixel counter. Sync pulses come from the timing generator and are not produced here.

Top module: `dotdash_renderer`

## Requirements
- R1: While `rst` is high, `green` is zero on the following cycle. After reset no band is lit until the line-counter has passed the top offset line (line 48) once.
- R2: Within a lit band line, pixel positions 0 to 3 of every cell are lit, whatever the bit value.
- R3: Positions 12 to 15 of every cell are always dark. For a one bit, positions 0 to 11 are lit. For a zero bit, positions 4 to 11 are dark.
- R4: Cell k covers pixels 64+16k to 79+16k and shows bit k of the word, so bit 0 is the leftmost cell and bit 31 the rightmost.
- R5: Word w is shown on lines 48+12w to 51+12w. Lines 52+12w to 59+12w are dark.
- R6: Pixels with x below 64 or from 576 upward, and lines below 48 or from 432 upward, are dark.
- R7: When `vid_active` is low, the next `green` is zero.
- R8: `green` is registered. The value after a rising edge reflects the pixel, line and active inputs that were sampled at that edge.
- R9: The word for a line is read from the store once, when the pixel counter equals 640 on the line before it. A write made after that read does not change the line being drawn. The write shows from the next line that fetches the word.
- R10: A write with `wr_en` high stores `wr_data` at `wr_addr`, and the stored value is the one drawn on that word's band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 10 | Pixel counter from the timing generator (0..799) |
| pix_y | input | 10 | Line counter from the timing generator (0..524) |
| vid_active | input | 1 | High during visible pixels |
| wr_en | input | 1 | Store write enable (processor port) |
| wr_addr | input | 5 | Store write word address |
| wr_data | input | 32 | Store write data |
| green | output | 4 | Green pixel intensity, all ones when lit |

## Verification
The store is first loaded with words that break symmetry: all zeros, all ones, a word with only its end bits set, and multiplied hash values. These show whether each cell draws the dot or the dash correctly and whether bit 0 is placed on the left rather than mirrored. For each band line, every pixel from just left of the window to just right of it is compared, and a blanked pass over the same line separates the active-video gating from the window gating. A second frame rewrites one word in the middle of its band and another word ahead of its band. This tells a design that samples the word once per line apart from one that reads the store live.

// File: rtl/dd_pkg.sv
package dd_pkg;
  // Store geometry
  localparam int DD_WORDS    = 32;
  localparam int DD_WORD_W   = 32;
  // Horizontal cell shape
  localparam int DD_CELL_W   = 16;
  localparam int DD_DOT_W    = 4;
  localparam int DD_DASH_W   = 12;
  // Vertical band shape
  localparam int DD_REPEAT   = 4;
  localparam int DD_PITCH    = 12;
  // Placement and raster
  localparam int DD_H_OFF    = 64;
  localparam int DD_V_OFF    = 48;
  localparam int DD_H_ACTIVE = 640;
  localparam int DD_V_TOTAL  = 525;
  localparam int DD_X_W      = 10;
  localparam int DD_Y_W      = 10;
  localparam int DD_COLOR_W  = 4;
endpackage

// File: rtl/dd_store_ram.sv
module dd_store_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read port, holds its value between reads
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/dd_row_tracker.sv
module dd_row_tracker #(
  parameter int X_W      = 10,
  parameter int Y_W      = 10,
  parameter int WORDS    = 32,
  parameter int REPEAT   = 4,
  parameter int PITCH    = 12,
  parameter int V_OFF    = 48,
  parameter int V_TOTAL  = 525,
  parameter int H_ACTIVE = 640,
  localparam int AW    = $clog2(WORDS),
  localparam int SUB_W = $clog2(PITCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [X_W-1:0]   pix_x,
  input  logic [Y_W-1:0]   pix_y,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             row_lit,
  output logic             in_win,
  output logic [SUB_W-1:0] sub
);
  logic             in_win_q, in_win_n;
  logic [SUB_W-1:0] sub_q, sub_n;
  logic [AW-1:0]    word_q, word_n;
  logic [Y_W-1:0]   next_y;
  logic             fetch;

  assign fetch  = (pix_x == X_W'(H_ACTIVE));
  assign next_y = (pix_y == Y_W'(V_TOTAL - 1)) ? '0 : pix_y + 1'b1;

  // Position within the band layout for the line that follows
  always_comb begin
    in_win_n = in_win_q;
    sub_n    = sub_q;
    word_n   = word_q;
    if (next_y == Y_W'(V_OFF)) begin
      in_win_n = 1'b1;
      sub_n    = '0;
      word_n   = '0;
    end else if (in_win_q) begin
      if (sub_q == SUB_W'(PITCH - 1)) begin
        sub_n = '0;
        if (word_q == AW'(WORDS - 1)) in_win_n = 1'b0;
        else                          word_n   = word_q + 1'b1;
      end else begin
        sub_n = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_win_q <= 1'b0;
      sub_q    <= '0;
      word_q   <= '0;
    end else if (fetch) begin
      in_win_q <= in_win_n;
      sub_q    <= sub_n;
      word_q   <= word_n;
    end
  end

  assign rd_en   = fetch & in_win_n;
  assign rd_addr = word_n;
  assign row_lit = in_win_q & (sub_q < SUB_W'(REPEAT));
  assign in_win  = in_win_q;
  assign sub     = sub_q;
endmodule

// File: rtl/dd_cell_shaper.sv
module dd_cell_shaper #(
  parameter int X_W    = 10,
  parameter int WORD_W = 32,
  parameter int CELL_W = 16,
  parameter int DOT_W  = 4,
  parameter int DASH_W = 12,
  parameter int H_OFF  = 64,
  localparam int CB    = $clog2(CELL_W),
  localparam int IW    = $clog2(WORD_W),
  localparam int REL_W = CB + IW,
  localparam int WIN_W = WORD_W * CELL_W
) (
  input  logic [X_W-1:0]    pix_x,
  input  logic [WORD_W-1:0] word,
  output logic              cell_on
);
  logic [REL_W-1:0] rel_x;
  logic [CB-1:0]    pos;
  logic [IW-1:0]    idx;
  logic             x_in;
  logic             bit_val;

  assign x_in    = (pix_x >= X_W'(H_OFF)) && (pix_x < X_W'(H_OFF + WIN_W));
  assign rel_x   = REL_W'(pix_x - X_W'(H_OFF));
  assign pos     = rel_x[CB-1:0];
  assign idx     = rel_x[CB +: IW];
  assign bit_val = word[idx];

  assign cell_on = x_in &&
                   (({1'b0, pos} < (CB+1)'(DOT_W)) ||
                    (bit_val && ({1'b0, pos} < (CB+1)'(DASH_W))));
endmodule

// File: rtl/dotdash_renderer.sv
module dotdash_renderer
  import dd_pkg::*;
#(
  parameter int WORDS    = DD_WORDS,
  parameter int WORD_W   = DD_WORD_W,
  parameter int CELL_W   = DD_CELL_W,
  parameter int DOT_W    = DD_DOT_W,
  parameter int DASH_W   = DD_DASH_W,
  parameter int REPEAT   = DD_REPEAT,
  parameter int PITCH    = DD_PITCH,
  parameter int H_OFF    = DD_H_OFF,
  parameter int V_OFF    = DD_V_OFF,
  parameter int H_ACTIVE = DD_H_ACTIVE,
  parameter int V_TOTAL  = DD_V_TOTAL,
  parameter int X_W      = DD_X_W,
  parameter int Y_W      = DD_Y_W,
  parameter int COLOR_W  = DD_COLOR_W,
  localparam int AW    = $clog2(WORDS),
  localparam int SUB_W = $clog2(PITCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  input  logic              vid_active,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [COLOR_W-1:0] green
);
  logic              rd_en;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] line_word;
  logic              row_lit;
  logic              trk_in_win;
  logic [SUB_W-1:0]  trk_sub;
  logic              cell_on;
  logic              lit_q;

  dd_store_ram #(.DEPTH(WORDS), .WIDTH(WORD_W)) i_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_q    (line_word)
  );

  dd_row_tracker #(
    .X_W(X_W), .Y_W(Y_W), .WORDS(WORDS), .REPEAT(REPEAT), .PITCH(PITCH),
    .V_OFF(V_OFF), .V_TOTAL(V_TOTAL), .H_ACTIVE(H_ACTIVE)
  ) i_rows (
    .clk     (clk),
    .rst     (rst),
    .pix_x   (pix_x),
    .pix_y   (pix_y),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .row_lit (row_lit),
    .in_win  (trk_in_win),
    .sub     (trk_sub)
  );

  dd_cell_shaper #(
    .X_W(X_W), .WORD_W(WORD_W), .CELL_W(CELL_W), .DOT_W(DOT_W),
    .DASH_W(DASH_W), .H_OFF(H_OFF)
  ) i_cells (
    .pix_x   (pix_x),
    .word    (line_word),
    .cell_on (cell_on)
  );

  always_ff @(posedge clk) begin
    if (rst) lit_q <= 1'b0;
    else     lit_q <= vid_active & row_lit & cell_on;
  end

  assign green = {COLOR_W{lit_q}};
endmodule

// File: rtl/dd_render_checker.sv
module dd_render_checker
  import dd_pkg::*;
#(
  localparam int CB    = $clog2(DD_CELL_W),
  localparam int SUB_W = $clog2(DD_PITCH),
  localparam int WIN_W = DD_WORD_W * DD_CELL_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic [DD_X_W-1:0]     pix_x,
  input logic [DD_Y_W-1:0]     pix_y,
  input logic                  vid_active,
  input logic [DD_COLOR_W-1:0] green,
  input logic                  row_lit,
  input logic                  rd_en,
  input logic                  in_win,
  input logic [SUB_W-1:0]      sub
);
  logic          x_in;
  logic [CB-1:0] pos;

  assign x_in = (pix_x >= DD_X_W'(DD_H_OFF)) && (pix_x < DD_X_W'(DD_H_OFF + WIN_W));
  assign pos  = CB'(pix_x - DD_X_W'(DD_H_OFF));

  AST_RESET_DARK: assert property (@(posedge clk)
    $past(rst) |-> green == '0); // R1
  AST_DOT_LIT: assert property (@(posedge clk) disable iff (rst)
    (vid_active && row_lit && x_in && ({1'b0, pos} < (CB+1)'(DD_DOT_W))) |=> green == '1); // R2
  AST_GAP_DARK: assert property (@(posedge clk) disable iff (rst)
    (x_in && ({1'b0, pos} >= (CB+1)'(DD_DASH_W))) |=> green == '0); // R3
  AST_ROW_DARK: assert property (@(posedge clk) disable iff (rst)
    !row_lit |=> green == '0); // R5
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
    in_win |-> sub < SUB_W'(DD_PITCH)); // R5
  AST_OUTSIDE_DARK: assert property (@(posedge clk) disable iff (rst)
    (!x_in || pix_y < DD_Y_W'(DD_V_OFF)) |=> green == '0); // R6
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    !vid_active |=> green == '0); // R7
  AST_FETCH_POINT: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> pix_x == DD_X_W'(DD_H_ACTIVE)); // R9
endmodule

bind dotdash_renderer dd_render_checker i_chk (
  .clk        (clk),
  .rst        (rst),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .vid_active (vid_active),
  .green      (green),
  .row_lit    (row_lit),
  .rd_en      (rd_en),
  .in_win     (trk_in_win),
  .sub        (trk_sub)
);

// File: tb/test_dotdash_renderer.sv
module test_dotdash_renderer;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  pix_x;
  logic [9:0]  pix_y;
  logic        vid_active;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  green;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] shadow [32];
  logic [31:0] cur_word = '0;
  string       phase = "R10";

  always #4 clk = ~clk;

  dotdash_renderer i_dotdash_renderer (
    .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .vid_active(vid_active),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .green(green)
  );

  // Requirement-level picture: window 64..575 x 48..431, cell 16, band 4 of 12
  function automatic bit exp_px(int x, int y, bit act, logic [31:0] w);
    int rx, ry, p;
    if (!act) return 1'b0;
    if (x < 64 || x >= 576 || y < 48 || y >= 432) return 1'b0;
    ry = y - 48;
    if (ry % 12 >= 4) return 1'b0;
    rx = x - 64;
    p  = rx % 16;
    return (p < 4) || (p < 12 && w[rx / 16] == 1'b1);
  endfunction

  function automatic string region(int x, int y, bit act);
    int p;
    if (!act) return "R7";
    if (x < 64 || x >= 576 || y < 48 || y >= 432) return "R6";
    if ((y - 48) % 12 >= 4) return "R5";
    p = (x - 64) % 16;
    if (p < 4)  return "R2";
    if (p >= 12) return "R3";
    return "R4";
  endfunction

  // One pixel per cycle; the model records the word fetched at x==640
  task automatic step(int x, int y, bit act, bit we = 1'b0, int wa = 0,
                      logic [31:0] wd = '0);
    bit    e;
    string tg;
    int    ny;
    pix_x = 10'(x); pix_y = 10'(y); vid_active = act;
    wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    e  = exp_px(x, y, act, cur_word);
    tg = region(x, y, act);
    if (x == 640) begin
      ny = (y == 524) ? 0 : y + 1;
      if (ny >= 48 && ny < 432) cur_word = shadow[(ny - 48) / 12];
    end
    if (we) shadow[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    n_tests++;
    if (green !== {4{e}}) begin
      n_fail++;
      $display("FAIL %s %s R8 x=%0d y=%0d actual=%h expected=%h",
               phase, tg, x, y, green, {4{e}});
    end
  endtask

  task automatic run_line(int y, int wx, int wa, logic [31:0] wd);
    bit band;
    band = (y >= 48 && y < 432 && (y - 48) % 12 < 4);
    if (band) begin
      step(0, y, 1'b1, wx == 0, wa, wd);
      step(1, y, 1'b1);
      for (int x = 60; x < 580; x++) step(x, y, 1'b1, x == wx, wa, wd);
      step(600, y, 1'b1);
      step(639, y, 1'b1);
      step(100, y, 1'b0);
    end else begin
      step(10, y, y < 480);
      step(70, y, y < 480);
      step(200, y, y < 480, wx == 200, wa, wd);
      step(639, y, y < 480);
    end
    step(640, y, 1'b0);
    step(700, y, 1'b0);
  endtask

  task automatic run_frame(int wy1, int wa1, logic [31:0] wd1,
                           int wy2, int wa2, logic [31:0] wd2);
    for (int y = 0; y < 525; y++) begin
      if (y == wy1)      run_line(y, 200, wa1, wd1);
      else if (y == wy2) run_line(y, 200, wa2, wd2);
      else               run_line(y, -1, 0, '0);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8 actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] pat;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    pix_x = 10'd64; pix_y = 10'd48; vid_active = 1'b1;
    // R1: reset holds the output dark even on a lit position
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      n_tests++;
      if (green !== 4'h0) begin
        n_fail++;
        $display("FAIL R1 reset actual=%h expected=0", green);
      end
    end
    rst = 1'b0;
    // R1: no band before the top line has been passed
    pix_x = 10'd64; pix_y = 10'd60; vid_active = 1'b1;
    @(posedge clk); @(negedge clk);
    n_tests++;
    if (green !== 4'h0) begin
      n_fail++;
      $display("FAIL R1 pre-window actual=%h expected=0", green);
    end
    // R10: load asymmetric patterns through the write port
    for (int w = 0; w < 32; w++) begin
      if (w == 0)       pat = 32'h0000_0000;
      else if (w == 1)  pat = 32'hFFFF_FFFF;
      else if (w == 31) pat = 32'h8000_0001;
      else              pat = (32'h9E37_79B9 * 32'(w + 1)) ^ (32'(w) << 7);
      step(700, 0, 1'b0, 1'b1, w, pat);
    end
    phase = "R10";
    run_frame(-1, 0, '0, -2, 0, '0);
    // R9: rewrite word 20 ahead of its band, word 5 in the middle of its band
    phase = "R9";
    run_frame(50, 20, 32'hFFFF_0000, 109, 5, 32'h0F0F_5A5A);
    finish_run();
  end
endmodule